// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is a write-only programming port for a radio front end. The host drives three pins: a serial clock, a serial data line and an active-low enable. The block samples all three into its own system clock domain. While the enable is low, each rising serial-clock edge pushes one data bit into a 24-bit shift register, most significant bit first. When the enable goes back high, the block commits the word. It then holds the decoded PLL and slot-control fields on registered outputs until the next accepted commit.

The block works out the word format from the two mode bits at positions 15 and 14. A 24-bit enhanced word carries those bits as `11` and adds an 8-bit delay field in the top byte. A 16-bit normal word carries them as `00` and uses only the low 16 bits. The host may clock in more bits than the word needs, and the block never counts the pulses: only the most recent bits stay in the register. A commit that carries either of the two mixed mode patterns is refused. The previous configuration stays in place and a one-cycle error pulse is raised.

Top module: `cfg3w_port`

## Requirements
- R1: While the synchronized enable is low, each rising edge of the serial clock shifts the serial data bit into bit 0 of the 24-bit register, so the first bit sent ends up as the most significant bit.
- R2: The decoded outputs change only on a commit, which is a low-to-high transition of the enable. Shifting alone leaves them untouched.
- R3: When more than 24 bits are sent in one frame, the earlier bits are dropped and only the last 24 bits sent are decoded.
- R4: On a commit with word bits [15:14] = 00, the block loads the normal-mode fields. The mode flag reads 0, the delay output reads 0, and word bits [23:16] have no effect.
- R5: On a commit with bits [15:14] = 11, the mode flag reads 1 and the delay output takes word bits [23:16].
- R6: The swallow output equals word bits [4:0], with a range of 0 to 31.
- R7: The main output equals 206 plus the 3-bit field in word bits [7:5], with a range of 206 to 213.
- R8: The reference select equals bit 8, the TX/RX slot bit equals bit 9 (1 = TX, 0 = RX), and the data-recovery enable equals bit 13. Bits [12:10] have no effect.
- R9: A commit with bits [15:14] = 01 or 10 leaves every configuration output unchanged and drives the error output high for exactly one system clock.
- R10: After reset, the outputs read swallow 0, main 206, reference select 0, slot bit 0, recovery 0, mode 0, delay 0 and error 0.
- R11: Serial clock edges that occur while the enable is high do not alter the shift register.
- R12: A new configuration appears on the outputs at the third rising system clock edge after the enable pin goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin (asynchronous) |
| ser_dat_i | input | 1 | Serial data pin (asynchronous) |
| ser_en_n_i | input | 1 | Active-low frame enable pin (asynchronous) |
| swallow_o | output | 5 | Swallow counter value |
| main_o | output | 8 | Main counter value, 206 to 213 |
| ref_sel_o | output | 1 | Reference clock select |
| tx_slot_o | output | 1 | 1 = TX slot, 0 = RX slot |
| recov_en_o | output | 1 | Data recovery enable |
| enh_mode_o | output | 1 | 1 = last accepted word was enhanced |
| delay_o | output | 8 | Enhanced-mode delay field, 0 in normal mode |
| err_o | output | 1 | One-cycle pulse on a rejected commit |

## Verification
The bench sends a frame of 30 bits. A design that cleared or counted bits would decode the wrong window, so the main, swallow and delay values would not match. It toggles the serial clock with the enable high and then commits an empty frame. A design that shifted on those edges would flip the slot bit. It commits both mixed mode patterns and checks that the configuration holds and the error pulse lasts exactly one cycle. It sends a normal word on top of leftover enhanced bits to show that the delay and mode flag fall to zero. A behavioural model follows the pin history cycle by cycle, so an extra or missing pipeline stage shows up as a mismatch one cycle early or late.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int unsigned WORD_W    = 24;
  localparam int unsigned SWAL_W    = 5;
  localparam int unsigned MFLD_W    = 3;
  localparam int unsigned MAIN_W    = 8;
  localparam int unsigned DLY_W     = 8;
  localparam int unsigned MAIN_BASE = 206;

  localparam int unsigned SWAL_LSB  = 0;
  localparam int unsigned MFLD_LSB  = 5;
  localparam int unsigned REF_BIT   = 8;
  localparam int unsigned TX_BIT    = 9;
  localparam int unsigned REC_BIT   = 13;
  localparam int unsigned MODE_LSB  = 14;
  localparam int unsigned DLY_LSB   = 16;

  typedef enum logic [1:0] {
    FMT_NORMAL = 2'b00,
    FMT_BAD_LO = 2'b01,
    FMT_BAD_HI = 2'b10,
    FMT_ENH    = 2'b11
  } fmt_e;

  typedef struct packed {
    logic [DLY_W-1:0]  delay;
    logic              enh;
    logic              recov;
    logic              tx;
    logic              refsel;
    logic [MAIN_W-1:0] main;
    logic [SWAL_W-1:0] swallow;
  } cfg_t;
endpackage

// File: rtl/cfg3w_rst_sync.sv
module cfg3w_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], d_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL[i]}};
      else        pipe_q <= pipe_d;
    end

    assign q_o[i] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift
  import cfg3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_dat,
  input  logic              s_en_n,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic              clk_prev_q;
  logic              en_prev_q;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_d;
  logic              shift_en;

  always_comb begin
    shift_en = s_clk & ~clk_prev_q & ~s_en_n;
    shift_d  = {shift_q[WORD_W-2:0], s_dat};
    commit_o = s_en_n & ~en_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      en_prev_q  <= 1'b1;
      shift_q    <= '0;
    end else begin
      clk_prev_q <= s_clk;
      en_prev_q  <= s_en_n;
      if (shift_en) shift_q <= shift_d;
    end
  end

  assign word_o = shift_q;

  // R11: no shifting while the frame enable is high
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_en_n |=> $stable(shift_q));

  // R1: a shift moves the old contents up by one place
  assert_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_clk && !clk_prev_q && !s_en_n) |=> (shift_q[WORD_W-1:1] == $past(shift_q[WORD_W-2:0])));
endmodule

// File: rtl/cfg3w_decode.sv
module cfg3w_decode
  import cfg3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output cfg_t              cfg_o,
  output logic              err_o
);
  fmt_e  fmt;
  logic  accept;
  logic  reject;
  cfg_t  cfg_d;
  cfg_t  cfg_q;
  logic  err_q;

  always_comb begin
    fmt    = fmt_e'(word_i[MODE_LSB +: 2]);
    accept = commit_i & ((fmt == FMT_NORMAL) | (fmt == FMT_ENH));
    reject = commit_i & ~accept;

    cfg_d.swallow = word_i[SWAL_LSB +: SWAL_W];
    cfg_d.main    = MAIN_W'(MAIN_BASE) + MAIN_W'(word_i[MFLD_LSB +: MFLD_W]);
    cfg_d.refsel  = word_i[REF_BIT];
    cfg_d.tx      = word_i[TX_BIT];
    cfg_d.recov   = word_i[REC_BIT];
    cfg_d.enh     = (fmt == FMT_ENH);
    cfg_d.delay   = (fmt == FMT_ENH) ? word_i[DLY_LSB +: DLY_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      cfg_q.main  <= MAIN_W'(MAIN_BASE);
      err_q       <= 1'b0;
    end else begin
      if (accept) cfg_q <= cfg_d;
      err_q <= reject;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  // R9: the error pulse lasts exactly one cycle
  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  // R9: a rejected commit leaves the configuration alone
  assert_err_keeps_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(cfg_q));

  // R7: main value stays inside its legal window
  assert_main_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.main >= MAIN_W'(MAIN_BASE)) && (cfg_q.main <= MAIN_W'(MAIN_BASE + 7)));

  // R4: a normal-mode configuration carries no delay
  assert_delay_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.enh |-> (cfg_q.delay == '0));
endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
  import cfg3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       ser_en_n_i,
  output logic [4:0] swallow_o,
  output logic [7:0] main_o,
  output logic       ref_sel_o,
  output logic       tx_slot_o,
  output logic       recov_en_o,
  output logic       enh_mode_o,
  output logic [7:0] delay_o,
  output logic       err_o
);
  localparam logic [2:0] PIN_IDLE = 3'b100;

  logic              rst_sync_n;
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              commit;
  cfg_t              cfg;

  cfg3w_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({ser_en_n_i, ser_dat_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  cfg3w_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .s_clk    (pins_s[0]),
    .s_dat    (pins_s[1]),
    .s_en_n   (pins_s[2]),
    .word_o   (word),
    .commit_o (commit)
  );

  cfg3w_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .commit_i (commit),
    .word_i   (word),
    .cfg_o    (cfg),
    .err_o    (err_o)
  );

  assign swallow_o  = cfg.swallow;
  assign main_o     = cfg.main;
  assign ref_sel_o  = cfg.refsel;
  assign tx_slot_o  = cfg.tx;
  assign recov_en_o = cfg.recov;
  assign enh_mode_o = cfg.enh;
  assign delay_o    = cfg.delay;

  // R2: configuration moves only on the cycle after a commit
  assert_update_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(cfg) |-> $past(commit));
endmodule

// File: tb/sim_cfg3w_port.sv
module sim_cfg3w_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdat = 1'b0;
  logic       sen_n = 1'b1;
  logic [4:0] swallow_o;
  logic [7:0] main_o;
  logic       ref_sel_o, tx_slot_o, recov_en_o, enh_mode_o, err_o;
  logic [7:0] delay_o;

  int n_cmp = 0;
  int n_bad = 0;
  int err_seen = 0;

  always #2 clk = ~clk;

  cfg3w_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_en_n_i(sen_n),
    .swallow_o(swallow_o), .main_o(main_o), .ref_sel_o(ref_sel_o), .tx_slot_o(tx_slot_o),
    .recov_en_o(recov_en_o), .enh_mode_o(enh_mode_o), .delay_o(delay_o), .err_o(err_o)
  );

  // behavioural reference: pin history, 24-bit window, decoded fields
  logic [2:0]  hc, hd, he;
  logic [23:0] m_sh;
  int          m_sw, m_main, m_ref, m_tx, m_rec, m_enh, m_dly, m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = 3'b000; hd = 3'b000; he = 3'b111; m_sh = 24'd0;
      m_sw = 0; m_main = 206; m_ref = 0; m_tx = 0; m_rec = 0; m_enh = 0; m_dly = 0; m_err = 0;
    end else begin
      m_err = 0;
      if (he[1] && !he[2]) begin
        if (m_sh[15] == m_sh[14]) begin
          m_sw   = int'(m_sh[4:0]);
          m_main = 206 + int'(m_sh[7:5]);
          m_ref  = int'(m_sh[8]);
          m_tx   = int'(m_sh[9]);
          m_rec  = int'(m_sh[13]);
          m_enh  = int'(m_sh[15]);
          m_dly  = m_sh[15] ? int'(m_sh[23:16]) : 0;
        end else begin
          m_err = 1;
        end
      end
      if (hc[1] && !hc[2] && !he[1]) m_sh = {m_sh[22:0], hd[1]};
      hc = {hc[1:0], sclk};
      hd = {hd[1:0], sdat};
      he = {he[1:0], sen_n};
    end
    if (rst_n && err_o) err_seen++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R12: every output matches the cycle-accurate model on each clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R12 swallow", int'(swallow_o), m_sw);
      chk("R12 main", int'(main_o), m_main);
      chk("R12 ref", int'(ref_sel_o), m_ref);
      chk("R12 tx", int'(tx_slot_o), m_tx);
      chk("R12 recov", int'(recov_en_o), m_rec);
      chk("R12 enh", int'(enh_mode_o), m_enh);
      chk("R12 delay", int'(delay_o), m_dly);
      chk("R12 err", int'(err_o), m_err);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sdat = b; tick(4);
    sclk = 1'b1; tick(4);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [31:0] w, input int n);
    sen_n = 1'b0; tick(3);
    for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
    tick(2);
    sen_n = 1'b1; tick(8);
  endtask

  task automatic expect_cfg(input string tag, input int sw, input int mn, input int rf,
                            input int tx, input int rc, input int en, input int dl);
    chk({tag, " swallow"}, int'(swallow_o), sw);
    chk({tag, " main"}, int'(main_o), mn);
    chk({tag, " ref"}, int'(ref_sel_o), rf);
    chk({tag, " tx"}, int'(tx_slot_o), tx);
    chk({tag, " recov"}, int'(recov_en_o), rc);
    chk({tag, " enh"}, int'(enh_mode_o), en);
    chk({tag, " delay"}, int'(delay_o), dl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(6);
    // R10: reset state
    expect_cfg("R10", 0, 206, 0, 0, 0, 0, 0);
    chk("R10 err", int'(err_o), 0);

    // R4 R6 R7 R8: normal word 0x22AB, with R2 mid-frame and R12 latency checks
    begin
      logic [15:0] w;
      w = 16'h22AB;
      sen_n = 1'b0; tick(3);
      for (int i = 15; i >= 8; i--) put_bit(w[i]);
      expect_cfg("R2 mid-frame", 0, 206, 0, 0, 0, 0, 0);
      for (int i = 7; i >= 0; i--) put_bit(w[i]);
      tick(2);
      expect_cfg("R2 before commit", 0, 206, 0, 0, 0, 0, 0);
      sen_n = 1'b1;
      tick(1); chk("R12 edge1 swallow", int'(swallow_o), 0);
      tick(1); chk("R12 edge2 swallow", int'(swallow_o), 0);
      tick(1); chk("R12 edge3 swallow", int'(swallow_o), 11);
      tick(6);
      expect_cfg("R4 R6 R7 R8 normal", 11, 211, 0, 1, 1, 0, 0);
    end

    // R5 R8: enhanced word, bits 12:10 set but ignored
    frame(32'hA5DDFF, 24);
    expect_cfg("R5 R8 enhanced", 31, 213, 1, 0, 0, 1, 165);

    // R11: clock pulses with enable high, then an empty frame re-commits the same word
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    frame(32'h0, 0);
    expect_cfg("R11 idle clocks", 31, 213, 1, 0, 0, 1, 165);

    // R3: 30-bit frame, six surplus leading ones
    frame(32'h3F3CC042, 30);
    expect_cfg("R3 overlong", 2, 208, 0, 0, 0, 1, 60);

    // R9: mixed mode patterns rejected
    err_seen = 0;
    frame(32'h00427F, 24);
    chk("R9 err pulse 01", err_seen, 1);
    expect_cfg("R9 kept 01", 2, 208, 0, 0, 0, 1, 60);
    err_seen = 0;
    frame(32'h8321, 16);
    chk("R9 err pulse 10", err_seen, 1);
    expect_cfg("R9 kept 10", 2, 208, 0, 0, 0, 1, 60);

    // R4 R1: 16-bit normal word over leftover upper bits
    frame(32'h0161, 16);
    expect_cfg("R4 R1 normal after enh", 1, 209, 1, 0, 0, 0, 0);

    // R6 R7: field extremes
    frame(32'h001F, 16);
    expect_cfg("R6 R7 extremes", 31, 206, 0, 0, 0, 0, 0);

    tick(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule